// File: doc/BRIEF.md
# Doorbell and Message Interrupt Unit

This block passes short messages and doorbell events between a host side and a local processor side. Each side has a simple synchronous register port with address, write data and write enable. Read data comes back combinationally from the current register state. There are two 32-bit message slots in each direction and one doorbell register in each direction. Each direction also has an interrupt status view and a mask register. One registered, active-high interrupt line goes to each side.

A writer posts into a message slot or sets doorbell bits. The reader reads the slot and then acknowledges, and the acknowledge path depends on the event type. A message flag is acknowledged through the status register. A doorbell is acknowledged by writing ones back into the doorbell register itself. Pending indications from an external queue engine arrive on input pins and are merged into the status views. One of those indications is never subject to masking.

Top module: `msgdb_unit`

Register offsets (word addresses, the same on both ports): 0 and 1 are inbound message slots 0 and 1, 2 and 3 are outbound message slots 0 and 1, 4 is the inbound doorbell, 5 is the outbound doorbell, 6 is the status view for the side's own interrupt, and 7 is the mask for that interrupt.

## Requirements
- R1: A host write to offset 0 or 1 stores the data in inbound slot 0 or 1 and sets inbound status bit 0 or 1. A local write to offset 2 or 3 stores the data in outbound slot 0 or 1 and sets outbound status bit 0 or 1. Both ports read every slot. A write to a slot the side does not own is ignored.
- R2: Writing ones at offset 6 clears message status bits 1:0 on that side: the local port clears inbound bits and the host port clears outbound bits. Zeros leave the bits unchanged. If a slot write and a clear of its bit land in the same cycle, the bit ends up set.
- R3: The status value read at offset 6 equals the raw status ANDed with the inverse of the mask. A mask bit of 1 hides its source and a 0 passes it.
- R4: The inbound status layout, read by the local port, is as follows. Bits 1:0 are the message flags. Bit 3 is set while any of inbound doorbell bits 30:0 is set. Bit 4 (machine check) is set while inbound doorbell bit 31 is set. Bit 5 follows input `in_post_q`. Bits 7 and 8 follow `in_ovf_q[0]` and `in_ovf_q[1]`. All other bits read zero.
- R5: The outbound status layout, read by the host port, is as follows. Bits 1:0 are the message flags. Bit 3 is set while the outbound doorbell is nonzero. Bit 5 follows `out_post_q` whatever the value of mask bit 5.
- R6: A host write at offset 4 ORs the data into the inbound doorbell. A local write at offset 4 clears every bit written as one. If both happen in the same cycle, the set wins. The doorbell indication stays pending while any bit remains set.
- R7: A local write at offset 5 ORs data bits 28:0 into the outbound doorbell, and bits 31:29 always read zero. A host write at offset 5 clears every bit written as one.
- R8: Writing ones to status bits 3 or 4 has no effect. These bits clear only when the doorbell bits behind them are cleared.
- R9: Each interrupt output is the OR of that side's unmasked status bits, registered. It changes on the clock edge after the status changes.
- R10: After reset, all slots, doorbells and flags are zero and both interrupts are low. The inbound mask reads 0x1BB (bits 0,1,3,4,5,7,8) and the outbound mask reads 0x2B (bits 0,1,3,5).
- R11: Mask writes keep only the implemented bits listed in R10, and all other mask bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_addr | input | 3 | Host port register offset |
| h_wdata | input | 32 | Host port write data |
| h_we | input | 1 | Host port write enable |
| h_rdata | output | 32 | Host port read data for `h_addr` |
| l_addr | input | 3 | Local port register offset |
| l_wdata | input | 32 | Local port write data |
| l_we | input | 1 | Local port write enable |
| l_rdata | output | 32 | Local port read data for `l_addr` |
| in_post_q | input | 1 | Inbound post-queue pending level from the queue engine |
| in_ovf_q | input | 2 | Inbound queue overflow levels from the queue engine |
| out_post_q | input | 1 | Outbound post-queue pending level, never masked |
| h_irq | output | 1 | Interrupt toward the host side |
| l_irq | output | 1 | Interrupt toward the local side |

## Verification
The assertions assume the queue inputs are level signals sampled on the clock edge. They also assume nothing other than the two register ports changes the doorbells or the message flags, so a doorbell with no local write at offset 4 must still hold its bits on the next cycle. The stimulus satisfies this by driving every input only at the falling edge. Queue levels change only between cycles, while a long random phase lets both ports hit every offset in the same cycle, including simultaneous set and clear.

// File: rtl/msgdb_pkg.sv
package msgdb_pkg;
  localparam int AW     = 3;
  localparam int NMSG   = 2;
  localparam int IST_W  = 9;
  localparam int OST_W  = 6;

  localparam logic [AW-1:0] A_IMSG0 = 3'd0;
  localparam logic [AW-1:0] A_IMSG1 = 3'd1;
  localparam logic [AW-1:0] A_OMSG0 = 3'd2;
  localparam logic [AW-1:0] A_OMSG1 = 3'd3;
  localparam logic [AW-1:0] A_IDB   = 3'd4;
  localparam logic [AW-1:0] A_ODB   = 3'd5;
  localparam logic [AW-1:0] A_STAT  = 3'd6;
  localparam logic [AW-1:0] A_MASK  = 3'd7;

  // implemented mask bits and the bits that ignore their mask
  localparam logic [IST_W-1:0] IN_MASK_IMPL  = 9'h1BB;
  localparam logic [IST_W-1:0] IN_BYPASS     = 9'h000;
  localparam logic [OST_W-1:0] OUT_MASK_IMPL = 6'h2B;
  localparam logic [OST_W-1:0] OUT_BYPASS    = 6'h20;
endpackage

// File: rtl/msgdb_doorbell.sv
module msgdb_doorbell #(
  parameter int W = 32,
  parameter logic [W-1:0] SET_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_val,
  input  logic         clr_en,
  input  logic [W-1:0] clr_val,
  output logic [W-1:0] bits_q
);
  logic [W-1:0] bits_d;
  logic         upd;

  assign upd = set_en | clr_en;

  // clear first, then set, so a simultaneous set wins
  always_comb begin
    bits_d = bits_q;
    if (clr_en) bits_d = bits_d & ~clr_val;
    if (set_en) bits_d = bits_d | (set_val & SET_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_d;
  end
endmodule

// File: rtl/msgdb_msgbank.sv
module msgdb_msgbank #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_en,
  input  logic [W-1:0]        wr_val,
  input  logic [N-1:0]        st_clr,
  output logic [N-1:0][W-1:0] msg_q,
  output logic [N-1:0]        st_q
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic st_d;
    logic st_upd;

    assign st_upd = wr_en[i] | st_clr[i];
    // a posting write overrides a clear in the same cycle
    always_comb begin
      st_d = st_q[i];
      if (st_clr[i]) st_d = 1'b0;
      if (wr_en[i])  st_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        msg_q[i] <= '0;
      else if (wr_en[i]) msg_q[i] <= wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q[i] <= 1'b0;
      else if (st_upd) st_q[i] <= st_d;
    end
  end
endmodule

// File: rtl/msgdb_irqctl.sv
module msgdb_irqctl #(
  parameter int SW = 9,
  parameter logic [SW-1:0] MASK_IMPL = '1,
  parameter logic [SW-1:0] BYPASS    = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] raw,
  input  logic          mask_we,
  input  logic [SW-1:0] mask_val,
  output logic [SW-1:0] mask_q,
  output logic [SW-1:0] rep,
  output logic          irq_q
);
  localparam logic [SW-1:0] EFFECTIVE = MASK_IMPL & ~BYPASS;

  logic [SW-1:0] mask_d;
  logic          irq_d;

  assign mask_d = mask_val & MASK_IMPL;
  assign rep    = raw & ~(mask_q & EFFECTIVE);
  assign irq_d  = |rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_IMPL;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/msgdb_unit.sv
module msgdb_unit #(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [msgdb_pkg::AW-1:0] h_addr,
  input  logic [DATA_W-1:0]       h_wdata,
  input  logic                    h_we,
  output logic [DATA_W-1:0]       h_rdata,
  input  logic [msgdb_pkg::AW-1:0] l_addr,
  input  logic [DATA_W-1:0]       l_wdata,
  input  logic                    l_we,
  output logic [DATA_W-1:0]       l_rdata,
  input  logic                    in_post_q,
  input  logic [1:0]              in_ovf_q,
  input  logic                    out_post_q,
  output logic                    h_irq,
  output logic                    l_irq
);
  import msgdb_pkg::*;

  localparam int NREG = 2 ** AW;
  localparam logic [DATA_W-1:0] ODB_SETTABLE = {3'b000, {(DATA_W-3){1'b1}}};
  localparam int MC_BIT = DATA_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // write decode
  logic [NREG-1:0] h_sel, l_sel;
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      h_sel[i] = h_we && (h_addr == AW'(i));
      l_sel[i] = l_we && (l_addr == AW'(i));
    end
  end

  // message slots
  logic [NMSG-1:0][DATA_W-1:0] imsg, omsg;
  logic [NMSG-1:0]             in_msg_st, out_msg_st;

  msgdb_msgbank #(.W(DATA_W), .N(NMSG)) u_inbank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  ({h_sel[A_IMSG1], h_sel[A_IMSG0]}),
    .wr_val (h_wdata),
    .st_clr (l_sel[A_STAT] ? l_wdata[NMSG-1:0] : '0),
    .msg_q  (imsg),
    .st_q   (in_msg_st)
  );

  msgdb_msgbank #(.W(DATA_W), .N(NMSG)) u_outbank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  ({l_sel[A_OMSG1], l_sel[A_OMSG0]}),
    .wr_val (l_wdata),
    .st_clr (h_sel[A_STAT] ? h_wdata[NMSG-1:0] : '0),
    .msg_q  (omsg),
    .st_q   (out_msg_st)
  );

  // doorbells
  logic [DATA_W-1:0] idb, odb;

  msgdb_doorbell #(.W(DATA_W), .SET_MASK('1)) u_idb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (h_sel[A_IDB]),
    .set_val (h_wdata),
    .clr_en  (l_sel[A_IDB]),
    .clr_val (l_wdata),
    .bits_q  (idb)
  );

  msgdb_doorbell #(.W(DATA_W), .SET_MASK(ODB_SETTABLE)) u_odb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_en  (l_sel[A_ODB]),
    .set_val (l_wdata),
    .clr_en  (h_sel[A_ODB]),
    .clr_val (h_wdata),
    .bits_q  (odb)
  );

  // status assembly
  logic [IST_W-1:0] in_raw, in_mask, in_rep;
  logic [OST_W-1:0] out_raw, out_mask, out_rep;
  logic             idb_pend, mc_pend, odb_pend;

  assign idb_pend = |idb[MC_BIT-1:0];
  assign mc_pend  = idb[MC_BIT];
  assign odb_pend = |odb;

  assign in_raw  = {in_ovf_q[1], in_ovf_q[0], 1'b0, in_post_q, mc_pend, idb_pend,
                    1'b0, in_msg_st};
  assign out_raw = {out_post_q, 1'b0, odb_pend, 1'b0, out_msg_st};

  msgdb_irqctl #(.SW(IST_W), .MASK_IMPL(IN_MASK_IMPL), .BYPASS(IN_BYPASS)) u_inirq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw      (in_raw),
    .mask_we  (l_sel[A_MASK]),
    .mask_val (l_wdata[IST_W-1:0]),
    .mask_q   (in_mask),
    .rep      (in_rep),
    .irq_q    (l_irq)
  );

  msgdb_irqctl #(.SW(OST_W), .MASK_IMPL(OUT_MASK_IMPL), .BYPASS(OUT_BYPASS)) u_outirq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw      (out_raw),
    .mask_we  (h_sel[A_MASK]),
    .mask_val (h_wdata[OST_W-1:0]),
    .mask_q   (out_mask),
    .rep      (out_rep),
    .irq_q    (h_irq)
  );

  // read paths: shared slots, side-specific status and mask
  always_comb begin
    case (h_addr)
      A_IMSG0: h_rdata = imsg[0];
      A_IMSG1: h_rdata = imsg[1];
      A_OMSG0: h_rdata = omsg[0];
      A_OMSG1: h_rdata = omsg[1];
      A_IDB:   h_rdata = idb;
      A_ODB:   h_rdata = odb;
      A_STAT:  h_rdata = DATA_W'(out_rep);
      default: h_rdata = DATA_W'(out_mask);
    endcase
  end

  always_comb begin
    case (l_addr)
      A_IMSG0: l_rdata = imsg[0];
      A_IMSG1: l_rdata = imsg[1];
      A_OMSG0: l_rdata = omsg[0];
      A_OMSG1: l_rdata = omsg[1];
      A_IDB:   l_rdata = idb;
      A_ODB:   l_rdata = odb;
      A_STAT:  l_rdata = DATA_W'(in_rep);
      default: l_rdata = DATA_W'(in_mask);
    endcase
  end
endmodule

// File: rtl/msgdb_unit_chk.sv
module msgdb_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     h_we,
  input logic [msgdb_pkg::AW-1:0] h_addr,
  input logic [DATA_W-1:0]        h_rdata,
  input logic                     l_we,
  input logic [msgdb_pkg::AW-1:0] l_addr,
  input logic                     l_irq,
  input logic [DATA_W-1:0]        idb,
  input logic [msgdb_pkg::IST_W-1:0] in_mask,
  input logic [msgdb_pkg::IST_W-1:0] in_rep,
  input logic [msgdb_pkg::NMSG-1:0]  in_msg_st
);
  import msgdb_pkg::*;

  // R2: a posting write sets its flag even against a same-cycle clear
  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(h_we && h_addr == A_IMSG0)) |-> in_msg_st[0]);

  // R3: fully masked inbound status never raises the local interrupt
  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(in_mask) == IN_MASK_IMPL) |-> !l_irq);

  // R6: a pending unmasked doorbell raises the local interrupt
  a_r6_db_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(idb[DATA_W-2:0] != '0) && !$past(in_mask[3])) |-> l_irq);

  // R8: doorbell bits survive any cycle without a local doorbell write
  a_r8_db_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(idb != '0) && !$past(l_we && l_addr == A_IDB)) |-> (idb != '0));

  // R7: outbound doorbell top three bits read zero on the host port
  a_r7_odb_top_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (h_addr == A_ODB) |-> (h_rdata[DATA_W-1:DATA_W-3] == 3'b000));

  // R9: local interrupt follows the previous cycle's reported status
  a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (l_irq == $past(|in_rep)));
endmodule

bind msgdb_unit msgdb_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .h_we       (h_we),
  .h_addr     (h_addr),
  .h_rdata    (h_rdata),
  .l_we       (l_we),
  .l_addr     (l_addr),
  .l_irq      (l_irq),
  .idb        (idb),
  .in_mask    (in_mask),
  .in_rep     (in_rep),
  .in_msg_st  (in_msg_st)
);

// File: tb/msgdb_unit_tb.sv
module msgdb_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  h_addr, l_addr;
  logic [31:0] h_wdata, l_wdata, h_rdata, l_rdata;
  logic        h_we, l_we;
  logic        in_post_q, out_post_q;
  logic [1:0]  in_ovf_q;
  logic        h_irq, l_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  msgdb_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_we(h_we), .h_rdata(h_rdata),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_we(l_we), .l_rdata(l_rdata),
    .in_post_q(in_post_q), .in_ovf_q(in_ovf_q), .out_post_q(out_post_q),
    .h_irq(h_irq), .l_irq(l_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_imsg [2];
  logic [31:0] m_omsg [2];
  logic [1:0]  m_ist, m_ost;
  logic [31:0] m_idb, m_odb, m_imask, m_omask;
  logic        m_hirq, m_lirq;

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin m_imsg[i] = 0; m_omsg[i] = 0; end
    m_ist = 0; m_ost = 0; m_idb = 0; m_odb = 0;
    m_imask = 32'h1BB; m_omask = 32'h2B; m_hirq = 0; m_lirq = 0;
  endtask

  function automatic logic [31:0] m_in_rep();
    logic [31:0] raw;
    raw = {30'd0, m_ist};
    if (m_idb[30:0] != 0) raw[3] = 1;
    if (m_idb[31])        raw[4] = 1;
    raw[5] = in_post_q; raw[7] = in_ovf_q[0]; raw[8] = in_ovf_q[1];
    return raw & ~m_imask;
  endfunction

  function automatic logic [31:0] m_out_rep();
    logic [31:0] raw;
    raw = {30'd0, m_ost};
    if (m_odb != 0) raw[3] = 1;
    raw[5] = out_post_q;
    return raw & ~(m_omask & 32'h0B);
  endfunction

  function automatic logic [31:0] m_read(input bit host, input logic [2:0] a);
    case (a)
      0: return m_imsg[0];
      1: return m_imsg[1];
      2: return m_omsg[0];
      3: return m_omsg[1];
      4: return m_idb;
      5: return m_odb;
      6: return host ? m_out_rep() : m_in_rep();
      default: return host ? m_omask : m_imask;
    endcase
  endfunction

  function automatic string tag_of(input bit host, input logic [2:0] a);
    case (a)
      0, 1, 2, 3: return "R1";
      4: return "R6";
      5: return "R7";
      6: return host ? "R5" : "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic m_clock();
    logic [31:0] ir, orp;
    ir = m_in_rep(); orp = m_out_rep();
    m_lirq = (ir != 0);
    m_hirq = (orp != 0);
    if (h_we && h_addr <= 1) m_imsg[h_addr[0]] = h_wdata;
    if (l_we && (l_addr == 2 || l_addr == 3)) m_omsg[l_addr[0]] = l_wdata;
    if (l_we && l_addr == 6) m_ist = m_ist & ~l_wdata[1:0];
    if (h_we && h_addr == 0) m_ist[0] = 1;
    if (h_we && h_addr == 1) m_ist[1] = 1;
    if (h_we && h_addr == 6) m_ost = m_ost & ~h_wdata[1:0];
    if (l_we && l_addr == 2) m_ost[0] = 1;
    if (l_we && l_addr == 3) m_ost[1] = 1;
    if (l_we && l_addr == 4) m_idb = m_idb & ~l_wdata;
    if (h_we && h_addr == 4) m_idb = m_idb | h_wdata;
    if (h_we && h_addr == 5) m_odb = m_odb & ~h_wdata;
    if (l_we && l_addr == 5) m_odb = m_odb | (l_wdata & 32'h1FFF_FFFF);
    if (l_we && l_addr == 7) m_imask = l_wdata & 32'h1BB;
    if (h_we && h_addr == 7) m_omask = h_wdata & 32'h2B;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk({tag_of(1, h_addr), " host read"},  h_rdata, m_read(1, h_addr));
    chk({tag_of(0, l_addr), " local read"}, l_rdata, m_read(0, l_addr));
    chk("R9 host irq",  {31'd0, h_irq}, {31'd0, m_hirq});
    chk("R9 local irq", {31'd0, l_irq}, {31'd0, m_lirq});
  endtask

  task automatic step(input logic hw, input logic [2:0] ha, input logic [31:0] hd,
                      input logic lw, input logic [2:0] la, input logic [31:0] ld);
    h_we = hw; h_addr = ha; h_wdata = hd;
    l_we = lw; l_addr = la; l_wdata = ld;
    @(posedge clk);
    m_clock();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic rd(input string tag, input bit host, input logic [2:0] a,
                    input logic [31:0] exp);
    step(0, host ? a : 3'd0, 0, 0, host ? 3'd0 : a, 0);
    chk(tag, host ? h_rdata : l_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; h_we = 0; l_we = 0; h_addr = 0; l_addr = 0; h_wdata = 0; l_wdata = 0;
    in_post_q = 0; out_post_q = 0; in_ovf_q = 0;
    m_reset();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) step(0, 0, 0, 0, 0, 0);

    // R10 reset state
    rd("R10 outbound mask", 1, 7, 32'h2B);
    rd("R10 inbound mask", 0, 7, 32'h1BB);
    chk("R10 host irq", {31'd0, h_irq}, 0);
    chk("R10 local irq", {31'd0, l_irq}, 0);
    rd("R10 outbound doorbell", 1, 5, 0);

    // R1 message posting
    step(1, 0, 32'hA5A5_0001, 0, 0, 0);
    rd("R1 inbound slot 0", 0, 0, 32'hA5A5_0001);
    step(0, 0, 0, 1, 7, 0);
    rd("R11 inbound mask cleared", 0, 7, 0);
    step(1, 1, 32'h0000_1234, 0, 0, 0);
    rd("R1 inbound flags", 0, 6, 32'h3);
    step(1, 2, 32'hDEAD_BEEF, 0, 0, 0);
    rd("R1 host cannot write outbound slot", 1, 2, 0);

    // R2 acknowledge through status register
    step(0, 0, 0, 1, 6, 32'h1);
    rd("R2 clear bit 0", 0, 6, 32'h2);
    step(0, 0, 0, 1, 6, 32'h0);
    rd("R2 zeros no effect", 0, 6, 32'h2);
    step(1, 0, 32'h77, 1, 6, 32'h3);
    rd("R2 set wins", 0, 6, 32'h1);

    // R9 one-cycle interrupt lag
    step(0, 0, 0, 1, 6, 32'h3);
    chk("R9 irq still high after clear edge", {31'd0, l_irq}, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R9 irq low one cycle later", {31'd0, l_irq}, 0);
    step(1, 0, 32'h55, 0, 0, 0);
    chk("R9 irq low on posting edge", {31'd0, l_irq}, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R9 irq high one cycle later", {31'd0, l_irq}, 1);
    step(0, 0, 0, 1, 6, 32'h3);

    // R6 inbound doorbell
    step(1, 4, 32'h5, 0, 0, 0);
    step(1, 4, 32'h8, 0, 0, 0);
    rd("R6 OR accumulate", 0, 4, 32'hD);
    step(0, 0, 0, 1, 4, 32'h4);
    rd("R6 write-one clear", 0, 4, 32'h9);
    rd("R6 pending while bits set", 0, 6, 32'h8);
    step(1, 4, 32'h2, 1, 4, 32'h2);
    rd("R6 set wins", 0, 4, 32'hB);
    step(0, 0, 0, 1, 4, 32'hFFFF_FFFF);
    rd("R6 cleared", 0, 6, 0);

    // R8 doorbell and machine check not cleared via status
    step(1, 4, 32'h8000_0001, 0, 0, 0);
    step(0, 0, 0, 1, 6, 32'h18);
    rd("R8 status write ignored", 0, 6, 32'h18);
    step(0, 0, 0, 1, 4, 32'h8000_0001);
    rd("R8 cleared via doorbell", 0, 6, 0);

    // R7 outbound doorbell
    step(0, 0, 0, 1, 5, 32'hFFFF_FFFF);
    rd("R7 top bits zero", 1, 5, 32'h1FFF_FFFF);
    step(1, 5, 32'hFF, 0, 0, 0);
    rd("R7 host clear", 1, 5, 32'h1FFF_FF00);
    step(1, 5, 32'hFFFF_FFFF, 0, 0, 0);

    // R5 unmaskable outbound post queue
    out_post_q = 1;
    rd("R5 post queue ignores mask", 1, 6, 32'h20);
    chk("R5 host irq from post queue", {31'd0, h_irq}, 1);
    out_post_q = 0;

    // R3 masking
    in_ovf_q = 2'b11;
    step(0, 0, 0, 1, 7, 32'h1BB);
    rd("R3 masked", 0, 6, 0);
    step(0, 0, 0, 1, 7, 0);
    rd("R3 unmasked", 0, 6, 32'h180);
    in_ovf_q = 2'b00;

    // R4 post queue position
    in_post_q = 1;
    rd("R4 post queue bit", 0, 6, 32'h20);
    in_post_q = 0;

    // R11 implemented bits only
    step(0, 0, 0, 1, 7, 32'hFFFF_FFFF);
    rd("R11 inbound mask bits", 0, 7, 32'h1BB);
    step(1, 7, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R11 outbound mask bits", 1, 7, 32'h2B);

    // mixed random traffic on both ports
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] hd, ld;
      hd = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      ld = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      if ($urandom % 8 == 0) ld = 0;
      if ($urandom % 16 == 0) begin
        in_post_q = $urandom; in_ovf_q = $urandom; out_post_q = $urandom;
      end
      step($urandom, $urandom, hd, $urandom, $urandom, ld);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule